// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block holds a 64-bit signed accumulator, kept as a high word and a low word, and adds a signed product to it on each start strobe. Two operand widths are offered. The full-word operation multiplies two signed 32-bit operands. The half-word operation multiplies the signed low 16 bits of each operand and ignores the upper bits. Each result then passes through a limiting rule that is chosen by a saturation-enable input. Each width has its own rule.

The block is used as the multiply-accumulate resource of a processor datapath. The processor issues one accumulate per strobe. It can load either half of the accumulator directly, clear both halves, and read both halves at any time. The update takes effect one clock after the strobe, and `done` pulses in that same cycle.

Top module: `sat_mac_unit`

## Requirements
- R1: While reset is asserted, and after it is released, both accumulator halves read zero and `done` is low.
- R2: With `start` high, `halfMode` low and `satEn` low, the accumulator {accHi, accLo} becomes its old value plus the signed 64-bit product of `opA` and `opB`, wrapping modulo 2^64.
- R3: With `start` high, `halfMode` high and `satEn` low, only `opA[15:0]` and `opB[15:0]` are used, each as a signed value. Their product is sign-extended to 64 bits and added to the accumulator with wrap-around. The upper operand bits have no effect.
- R4: In word mode with `satEn` high, a negative 64-bit sum sets accHi[31:16] to all ones. accLo keeps the computed low word.
- R5: In word mode with `satEn` high, a non-negative sum clears accHi[31:15]. The other bits keep their computed values.
- R6: In half-word mode with `satEn` high, a sum below -2^31 leaves accHi = 0x00000001 and accLo = 0x80000000.
- R7: In half-word mode with `satEn` high, a sum above 2^31-1 leaves accHi = 0x00000001 and accLo = 0x7FFFFFFF. A sum inside that range is written unchanged.
- R8: `clrAcc` high without `start` zeroes both halves at the next clock edge.
- R9: `wrHi` loads `wrData` into accHi, and `wrLo` loads `wrData` into accLo. Both may act in the same cycle.
- R10: Priority order: `start` first, then `clrAcc`, then the loads. A lower-priority request issued together with a higher one is ignored.
- R11: `done` is high exactly in the cycle after a cycle with `start` high. The new accumulator value is visible in that cycle.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accumulate strobe |
| halfMode | input | 1 | 1 = 16-bit operands, 0 = 32-bit operands |
| satEn | input | 1 | Enables the limiting rule of the selected mode |
| opA | input | 32 | First multiplier operand |
| opB | input | 32 | Second multiplier operand |
| clrAcc | input | 1 | Synchronous clear of both halves |
| wrHi | input | 1 | Load accHi from wrData |
| wrLo | input | 1 | Load accLo from wrData |
| wrData | input | 32 | Load data |
| accHi | output | 32 | High accumulator word |
| accLo | output | 32 | Low accumulator word |
| done | output | 1 | One-cycle pulse marking a completed accumulate |

## Verification
Word products are tried in four forms:
- positive by positive;
- mixed signs;
- operands that carry out of the low word into the high word;
- a sum that wraps past the top of the 64-bit range, which separates modular wrap from clamping.

Half-word operations use operands whose upper 16 bits hold unrelated data, so a design that reads those bits gives a different answer. With saturation enabled, the accumulator is preloaded just inside and just outside the 32-bit range. This tells the in-range pass-through apart from each clamp direction, and shows that the word-mode masking of accHi depends on the sign of the full 64-bit sum. Requests that arrive in the same cycle (accumulate with clear, accumulate with loads, clear with loads) check the priority order.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // strobes passed from the control to the datapath for one clock
  typedef struct packed {
    logic accum;   // perform multiply-accumulate
    logic half;    // 16-bit operand mode
    logic sat;     // apply limiting rule
    logic clr;     // zero both halves
    logic ldHi;    // load high half
    logic ldLo;    // load low half
  } macStrobes_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        halfMode,
  input  logic        satEn,
  input  logic        clrAcc,
  input  logic        wrHi,
  input  logic        wrLo,
  output macStrobes_t strobes,
  output logic        done
);
  // priority: accumulate, then clear, then direct loads
  always_comb begin
    strobes.accum = start;
    strobes.half  = halfMode;
    strobes.sat   = satEn;
    strobes.clr   = clrAcc & ~start;
    strobes.ldHi  = wrHi & ~start & ~clrAcc;
    strobes.ldLo  = wrLo & ~start & ~clrAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  macStrobes_t  strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] accHi,
  output logic [W-1:0] accLo
);
  localparam int AW = 2 * W;
  localparam int PW = 2 * HW;

  logic [AW-1:0]        extA, extB, prodWord, prodHalf, prodSel;
  logic signed [HW-1:0] aHalf, bHalf;
  logic signed [PW-1:0] pHalf;
  logic signed [AW-1:0] sumS;
  logic [W-1:0]         nextHi, nextLo;
  logic                 belowMin, aboveMax;

  // product of the two widths
  always_comb begin
    extA     = {{W{opA[W-1]}}, opA};
    extB     = {{W{opB[W-1]}}, opB};
    prodWord = extA * extB;
    aHalf    = opA[HW-1:0];
    bHalf    = opB[HW-1:0];
    pHalf    = aHalf * bHalf;
    prodHalf = {{(AW-PW){pHalf[PW-1]}}, pHalf};
    prodSel  = strobes.half ? prodHalf : prodWord;
    sumS     = $signed({accHi, accLo} + prodSel);
  end

  // limiting rules
  always_comb begin
    belowMin = sumS < $signed({{(W+1){1'b1}}, {(W-1){1'b0}}});
    aboveMax = sumS > $signed({{(W+1){1'b0}}, {(W-1){1'b1}}});
    nextHi   = sumS[AW-1:W];
    nextLo   = sumS[W-1:0];
    if (strobes.sat) begin
      if (!strobes.half) begin
        if (sumS[AW-1]) nextHi[W-1:HW]   = '1;
        else            nextHi[W-1:HW-1] = '0;
      end else if (belowMin) begin
        nextHi = W'(1);
        nextLo = {1'b1, {(W-1){1'b0}}};
      end else if (aboveMax) begin
        nextHi = W'(1);
        nextLo = {1'b0, {(W-1){1'b1}}};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accHi <= '0;
      accLo <= '0;
    end else if (strobes.accum) begin
      accHi <= nextHi;
      accLo <= nextLo;
    end else if (strobes.clr) begin
      accHi <= '0;
      accLo <= '0;
    end else begin
      if (strobes.ldHi) accHi <= wrData;
      if (strobes.ldLo) accLo <= wrData;
    end
  end
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import mac_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         halfMode,
  input  logic         satEn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         clrAcc,
  input  logic         wrHi,
  input  logic         wrLo,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] accHi,
  output logic [W-1:0] accLo,
  output logic         done
);
  macStrobes_t strobes;

  mac_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .halfMode(halfMode), .satEn(satEn),
    .clrAcc(clrAcc), .wrHi(wrHi), .wrLo(wrLo), .strobes(strobes), .done(done)
  );

  mac_datapath #(.W(W), .HW(HW)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opA(opA), .opB(opB),
    .wrData(wrData), .accHi(accHi), .accLo(accLo)
  );
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         halfMode,
  input logic         satEn,
  input logic         clrAcc,
  input logic         wrHi,
  input logic         wrLo,
  input logic [W-1:0] wrData,
  input logic [W-1:0] accHi,
  input logic [W-1:0] accLo,
  input logic         done
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rstN) start |=> done); // R11
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN) !start |=> !done); // R11
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    (clrAcc && !start) |=> (accHi == '0 && accLo == '0)); // R8
  AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && !start && !clrAcc) |=> accHi == $past(wrData)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !clrAcc && !wrHi && !wrLo) |=> ($stable(accHi) && $stable(accLo))); // R10
  AST_WORD_SAT_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (start && !halfMode && satEn) |=> (accHi[W-1:HW] == '1 || accHi[W-1:HW-1] == '0)); // R4
  AST_HALF_SAT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (start && halfMode && satEn) |=>
      ((accHi == W'(1) && (accLo == {1'b1, {(W-1){1'b0}}} || accLo == {1'b0, {(W-1){1'b1}}}))
       || accHi == {W{accLo[W-1]}})); // R7
endmodule

bind sat_mac_unit mac_checker #(.W(W), .HW(HW)) i_chk (
  .clk(clk), .rstN(rstN), .start(start), .halfMode(halfMode), .satEn(satEn),
  .clrAcc(clrAcc), .wrHi(wrHi), .wrLo(wrLo), .wrData(wrData),
  .accHi(accHi), .accLo(accLo), .done(done)
);

// File: tb/test_sat_mac_unit.sv
`timescale 1ns/1ps
module test_sat_mac_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 0, halfMode = 0, satEn = 0, clrAcc = 0, wrHi = 0, wrLo = 0;
  logic [31:0] opA = '0, opB = '0, wrData = '0;
  logic [31:0] accHi, accLo;
  logic done;

  int total = 0, bad = 0;
  bit checking = 0;
  string curReq = "R1";

  longint mAcc = 0;
  bit mDone = 0;

  always #2.5 clk = ~clk;

  sat_mac_unit i_sat_mac_unit (
    .clk(clk), .rstN(rstN), .start(start), .halfMode(halfMode), .satEn(satEn),
    .opA(opA), .opB(opB), .clrAcc(clrAcc), .wrHi(wrHi), .wrLo(wrLo),
    .wrData(wrData), .accHi(accHi), .accLo(accLo), .done(done)
  );

  // behavioural reference model
  always @(posedge clk) begin
    longint prod, sum;
    logic [31:0] hi, lo;
    if (!rstN) begin
      mAcc = 0; mDone = 0;
    end else begin
      mDone = start;
      if (start) begin
        if (halfMode) prod = longint'($signed(opA[15:0])) * longint'($signed(opB[15:0]));
        else          prod = longint'($signed(opA)) * longint'($signed(opB));
        sum = mAcc + prod;
        hi = sum[63:32]; lo = sum[31:0];
        if (satEn && !halfMode) begin
          if (sum < 0) hi = hi | 32'hFFFF0000;
          else         hi = hi & 32'h00007FFF;
        end else if (satEn && halfMode) begin
          if (sum < -64'sd2147483648) begin hi = 1; lo = 32'h80000000; end
          else if (sum > 64'sd2147483647) begin hi = 1; lo = 32'h7FFFFFFF; end
        end
        mAcc = {hi, lo};
      end else if (clrAcc) begin
        mAcc = 0;
      end else begin
        hi = mAcc[63:32]; lo = mAcc[31:0];
        if (wrHi) hi = wrData;
        if (wrLo) lo = wrData;
        mAcc = {hi, lo};
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      total++;
      if (accHi !== mAcc[63:32] || accLo !== mAcc[31:0] || done !== mDone) begin
        bad++;
        $display("FAIL %s: got hi=%h lo=%h done=%b expected hi=%h lo=%h done=%b",
                 curReq, accHi, accLo, done, mAcc[63:32], mAcc[31:0], mDone);
      end
    end
  end

  task automatic idle();
    start = 0; clrAcc = 0; wrHi = 0; wrLo = 0;
  endtask

  task automatic mac(input bit h, input bit s, input logic [31:0] a, input logic [31:0] b);
    start = 1; halfMode = h; satEn = s; opA = a; opB = b;
    @(negedge clk); idle();
  endtask

  task automatic load(input logic [31:0] hi, input logic [31:0] lo);
    wrHi = 1; wrData = hi; @(negedge clk); idle();
    wrLo = 1; wrData = lo; @(negedge clk); idle();
  endtask

  task automatic clear();
    clrAcc = 1; @(negedge clk); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    total++;
    if (accHi !== 0 || accLo !== 0 || done !== 0) begin
      bad++;
      $display("FAIL R1: got hi=%h lo=%h done=%b expected zeros", accHi, accLo, done);
    end
    rstN = 1;
    @(negedge clk);
    checking = 1;
    @(negedge clk);

    curReq = "R2";
    mac(0, 0, 32'd1000, 32'd3000);
    mac(0, 0, 32'hFFFFFFF9, 32'd12345);
    mac(0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF);
    load(32'h7FFFFFFF, 32'hFFFFFFFF);
    mac(0, 0, 32'd1, 32'd1);
    curReq = "R11"; @(negedge clk); @(negedge clk);

    curReq = "R3";
    clear();
    mac(1, 0, 32'hABCD0003, 32'h1234FFFE);
    mac(1, 0, 32'h00008000, 32'hFFFF8000);
    mac(1, 0, 32'h5A5A7FFF, 32'hA5A58000);

    curReq = "R4";
    load(32'h80001234, 32'h0);
    mac(0, 1, 32'd1, 32'd1);
    clear();
    mac(0, 1, 32'hFFFFFFFD, 32'd5);
    curReq = "R5";
    load(32'h00001234, 32'h0);
    mac(0, 1, 32'hFFFFFFFF, 32'd1);
    load(32'h7FFF8000, 32'h0);
    mac(0, 1, 32'd1, 32'd1);

    curReq = "R6";
    load(32'hFFFFFFFF, 32'h80000010);
    mac(1, 1, 32'h00008000, 32'h00007FFF);
    curReq = "R7";
    load(32'h0, 32'h7FFF0000);
    mac(1, 1, 32'h00007FFF, 32'h00007FFF);
    clear();
    mac(1, 1, 32'd100, 32'hFFFFFF38);
    load(32'hFFFFFFFF, 32'h80000000);
    mac(1, 1, 32'd0, 32'd0);

    curReq = "R8";
    load(32'h12345678, 32'h9ABCDEF0);
    clear();
    curReq = "R9";
    wrHi = 1; wrLo = 1; wrData = 32'hCAFEF00D; @(negedge clk); idle();
    load(32'h00000011, 32'h00000022);

    curReq = "R10";
    start = 1; clrAcc = 1; halfMode = 0; satEn = 0; opA = 32'd7; opB = 32'd9;
    @(negedge clk); idle();
    start = 1; wrHi = 1; wrLo = 1; wrData = 32'hDEADBEEF; opA = 32'd2; opB = 32'd3;
    @(negedge clk); idle();
    clrAcc = 1; wrHi = 1; wrData = 32'h55555555;
    @(negedge clk); idle();

    curReq = "R11";
    mac(0, 0, 32'd4, 32'd4);
    mac(1, 0, 32'd4, 32'd4);
    repeat (3) @(negedge clk);

    checking = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule